// File: doc/BRIEF.md
# Split Safe/Unsafe Store Buffer

This block buffers retired stores for a core that keeps sequential consistency. Each store or load carries two classification flags, one set at decode and one from address translation. An access counts as safe when either flag is set. Safe stores go into one FIFO and unsafe stores into another. Both FIFOs share a single cache write port.

Loads follow rules that differ by class. A safe load searches only the safe FIFO and forwards the youngest matching store in the same cycle. An unsafe load never forwards. It is held off while any unsafe store is still buffered, and once that FIFO is empty it proceeds to the cache. A drain request blocks new stores, and it is acknowledged once both FIFOs are empty. Logic outside the block uses this when a page is reclassified from safe to unsafe.

Top module: `split_store_buffer`

## Requirements
- R1: A store or load is classified safe when `st_safe_static` OR `st_safe_dyn` (respectively `ld_safe_static` OR `ld_safe_dyn`) is 1. The store enters the safe FIFO only in that case, and the unsafe FIFO otherwise.
- R2: A valid safe load raises `ld_hit` in the same cycle if the safe FIFO holds its address. `ld_data` then carries the data of the youngest such entry. Unsafe FIFO contents never produce a hit.
- R3: A valid unsafe load never raises `ld_hit`. It raises `ld_stall` exactly while the unsafe FIFO is non-empty, and safe FIFO contents do not stall it.
- R4: Each FIFO writes its entries to the cache port in the order they were accepted.
- R5: When both FIFOs hold entries, the cache port presents the unsafe FIFO's head. The safe FIFO is not popped in that cycle.
- R6: `mem_valid` is 1 while either FIFO holds an entry. An entry leaves only on a cycle where `mem_ready` is 1, and with `mem_ready` at 0 nothing is lost.
- R7: `st_ready` is 0 when the FIFO selected by the store's class holds DEPTH entries (default 4), and a store offered then is not taken.
- R8: While `drain_req` is 1, `st_ready` is 0 and no store is taken. `drain_ack` is 1 only while `drain_req` is 1 and both FIFOs are empty.
- R9: After reset both FIFOs are empty, `mem_valid` is 0 and `st_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_safe_static | input | 1 | Decode-time safe flag of the store |
| st_safe_dyn | input | 1 | Translation-time safe flag of the store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store can be taken this cycle |
| ld_valid | input | 1 | Load lookup |
| ld_safe_static | input | 1 | Decode-time safe flag of the load |
| ld_safe_dyn | input | 1 | Translation-time safe flag of the load |
| ld_addr | input | AW | Load address |
| ld_hit | output | 1 | Forwarded from safe FIFO |
| ld_data | output | DW | Forwarded data |
| ld_stall | output | 1 | Unsafe load must wait |
| mem_valid | output | 1 | Cache write pending |
| mem_addr | output | AW | Cache write address |
| mem_data | output | DW | Cache write data |
| mem_ready | input | 1 | Cache accepts the write |
| drain_req | input | 1 | Request to empty both FIFOs |
| drain_ack | output | 1 | Both FIFOs empty during a drain |

## Verification
Four properties are checked on every cycle. Occupancy never exceeds DEPTH. An unsafe load is never forwarded. Occupancy never grows during a drain. A cycle that writes from the unsafe FIFO never also empties an entry of the safe FIFO. The scenarios are needed to show the rest: the OR of the two flags, selection of the youngest match, FIFO order and priority on the shared port, the full-FIFO refusal, and the timing of the drain handshake.

// File: rtl/split_store_buffer.sv
module split_store_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic          st_safe_static,
  input  logic          st_safe_dyn,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_ready,
  input  logic          ld_valid,
  input  logic          ld_safe_static,
  input  logic          ld_safe_dyn,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          ld_stall,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  input  logic          drain_req,
  output logic          drain_ack
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam int SAFE = 0;
  localparam int UNSF = 1;

  logic [AW-1:0] addr_q [2][DEPTH];
  logic [DW-1:0] data_q [2][DEPTH];
  logic [PW-1:0] head [2];
  logic [PW-1:0] tail [2];
  logic [CW-1:0] cnt  [2];
  logic [1:0]    push, pop;

  wire st_is_safe = st_safe_static | st_safe_dyn;
  wire ld_is_safe = ld_safe_static | ld_safe_dyn;
  wire u_busy     = cnt[UNSF] != '0;
  wire s_busy     = cnt[SAFE] != '0;
  wire st_fire    = st_valid & st_ready;

  assign st_ready  = !drain_req && (st_is_safe ? cnt[SAFE] != CW'(DEPTH)
                                               : cnt[UNSF] != CW'(DEPTH));
  assign push      = {st_fire & ~st_is_safe, st_fire & st_is_safe};
  assign pop       = {mem_ready & u_busy, mem_ready & ~u_busy & s_busy};
  assign mem_valid = u_busy | s_busy;
  assign mem_addr  = u_busy ? addr_q[UNSF][head[UNSF]] : addr_q[SAFE][head[SAFE]];
  assign mem_data  = u_busy ? data_q[UNSF][head[UNSF]] : data_q[SAFE][head[SAFE]];
  assign drain_ack = drain_req & ~mem_valid;
  assign ld_stall  = ld_valid & ~ld_is_safe & u_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        head[b] <= '0;
        tail[b] <= '0;
        cnt[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (push[b]) tail[b] <= tail[b] + PW'(1);
        if (pop[b])  head[b] <= head[b] + PW'(1);
        cnt[b] <= cnt[b] + CW'(push[b]) - CW'(pop[b]);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (push[b]) begin
        addr_q[b][tail[b]] <= st_addr;
        data_q[b][tail[b]] <= st_data;
      end
    end
  end

  logic          fwd_hit;
  logic [DW-1:0] fwd_data;
  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt[SAFE] &&
          addr_q[SAFE][head[SAFE] + PW'(i)] == ld_addr) begin
        fwd_hit  = 1'b1;
        fwd_data = data_q[SAFE][head[SAFE] + PW'(i)];
      end
    end
  end

  assign ld_hit  = ld_valid & ld_is_safe & fwd_hit;
  assign ld_data = fwd_data;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[SAFE] <= CW'(DEPTH) && cnt[UNSF] <= CW'(DEPTH));

  assert_unsafe_never_forwarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_is_safe) |-> !ld_hit);

  assert_drain_freezes_intake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |=> (cnt[SAFE] <= $past(cnt[SAFE]) && cnt[UNSF] <= $past(cnt[UNSF])));

  assert_unsafe_wins_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ready && u_busy) |=> cnt[SAFE] >= $past(cnt[SAFE]));
endmodule

// File: tb/test_split_store_buffer.sv
`timescale 1ns/100ps
module test_split_store_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 0, st_safe_static = 0, st_safe_dyn = 0;
  logic [15:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic st_ready;
  logic ld_valid = 0, ld_safe_static = 0, ld_safe_dyn = 0;
  logic [15:0] ld_addr = '0;
  logic ld_hit, ld_stall;
  logic [31:0] ld_data;
  logic mem_valid;
  logic [15:0] mem_addr;
  logic [31:0] mem_data;
  logic mem_ready = 0, drain_req = 0, drain_ack;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  split_store_buffer i_split_store_buffer (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic ss, input logic sd, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1; st_safe_static = ss; st_safe_dyn = sd; st_addr = a; st_data = d;
    @(posedge clk); #1;
    st_valid = 0;
  endtask

  task automatic probe_load(input logic ss, input logic sd, input logic [15:0] a,
                            input logic eh, input logic [31:0] ed, input logic es, input string req);
    @(negedge clk);
    ld_valid = 1; ld_safe_static = ss; ld_safe_dyn = sd; ld_addr = a;
    #1;
    chk(ld_hit == eh, req, 32'(ld_hit), 32'(eh));
    if (eh) chk(ld_data == ed, req, ld_data, ed);
    chk(ld_stall == es, req, 32'(ld_stall), 32'(es));
    ld_valid = 0;
  endtask

  task automatic expect_pop(input logic [15:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    mem_ready = 1;
    #1;
    chk(mem_valid == 1'b1, req, 32'(mem_valid), 32'd1);
    chk(mem_addr == a, req, 32'(mem_addr), 32'(a));
    chk(mem_data == d, req, mem_data, d);
    @(posedge clk); #1;
    mem_ready = 0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(mem_valid == 0, "R9 mem_valid", 32'(mem_valid), 0);
    chk(st_ready == 1, "R9 st_ready", 32'(st_ready), 1);
    chk(drain_ack == 0, "R9 drain_ack", 32'(drain_ack), 0);
  endtask

  task automatic t_forward_order;
    do_store(1, 0, 16'h0010, 32'hA0A0_0001);
    do_store(0, 1, 16'h0010, 32'hB0B0_0002);
    do_store(0, 0, 16'h0010, 32'hC0C0_0003);
    do_store(1, 1, 16'h0030, 32'hD0D0_0004);
    probe_load(1, 0, 16'h0010, 1, 32'hB0B0_0002, 0, "R2 youngest match");
    probe_load(0, 1, 16'h0030, 1, 32'hD0D0_0004, 0, "R1 dyn flag selects safe");
    probe_load(1, 0, 16'h0020, 0, 0, 0, "R2 miss");
    probe_load(0, 0, 16'h0010, 0, 0, 1, "R3 unsafe load stalls");
    @(negedge clk); #1;
    chk(mem_addr == 16'h0010 && mem_data == 32'hC0C0_0003, "R5 unsafe head shown", mem_data, 32'hC0C0_0003);
    @(negedge clk); #1;
    chk(mem_valid && mem_data == 32'hC0C0_0003, "R6 held without ready", mem_data, 32'hC0C0_0003);
    expect_pop(16'h0010, 32'hC0C0_0003, "R5 unsafe first");
    probe_load(0, 0, 16'h0010, 0, 0, 0, "R3 no stall once unsafe empty");
    probe_load(1, 1, 16'h0010, 1, 32'hB0B0_0002, 0, "R2 still forwards");
    expect_pop(16'h0010, 32'hA0A0_0001, "R4 safe order 1");
    expect_pop(16'h0010, 32'hB0B0_0002, "R4 safe order 2");
    expect_pop(16'h0030, 32'hD0D0_0004, "R4 safe order 3");
    @(negedge clk); #1;
    chk(mem_valid == 0, "R6 empty", 32'(mem_valid), 0);
  endtask

  task automatic t_full;
    for (int k = 0; k < 4; k++) do_store(0, 0, 16'(16'h0100 + k), 32'(32'h5500 + k));
    @(negedge clk);
    st_safe_static = 0; st_safe_dyn = 0; #1;
    chk(st_ready == 0, "R7 unsafe full", 32'(st_ready), 0);
    st_safe_static = 1; #1;
    chk(st_ready == 1, "R7 safe still open", 32'(st_ready), 1);
    do_store(0, 0, 16'h01FF, 32'hDEAD_BEEF);
    for (int k = 0; k < 4; k++) expect_pop(16'(16'h0100 + k), 32'(32'h5500 + k), "R7 R4 unsafe order");
    @(negedge clk); #1;
    chk(mem_valid == 0, "R7 extra store dropped", 32'(mem_valid), 0);
  endtask

  task automatic t_drain;
    do_store(1, 0, 16'h0040, 32'h4000_0040);
    do_store(0, 1, 16'h0041, 32'h4000_0041);
    @(negedge clk);
    drain_req = 1; st_safe_static = 1; #1;
    chk(st_ready == 0, "R8 intake closed", 32'(st_ready), 0);
    chk(drain_ack == 0, "R8 no early ack", 32'(drain_ack), 0);
    probe_load(0, 0, 16'h0040, 0, 0, 0, "R3 safe contents do not stall");
    do_store(1, 0, 16'h0042, 32'h4000_0042);
    expect_pop(16'h0040, 32'h4000_0040, "R8 drain pop 1");
    expect_pop(16'h0041, 32'h4000_0041, "R8 drain pop 2");
    @(negedge clk); #1;
    chk(drain_ack == 1, "R8 ack when empty", 32'(drain_ack), 1);
    chk(mem_valid == 0, "R8 blocked store not taken", 32'(mem_valid), 0);
    drain_req = 0; #1;
    chk(drain_ack == 0 && st_ready == 1, "R8 release", 32'(st_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_forward_order();
    t_full();
    t_drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule